// File: doc/BRIEF.md
# Short I/O to Byte-Wide Remote Bus Bridge

This block sits on a backplane as a slave in the 16-bit short I/O space and turns each accepted access into one slow, strobed transfer on a remote 8-bit parallel I/O bus. A static 6-bit setting places the block on one of 64 windows of 1 KiB each. A static select picks which address-modifier class it accepts. Only the odd byte lane carries data, so a word access moves one byte.

For every accepted cycle the block latches the remote address and the write data. It then opens a fixed strobe window on the remote bus and latches read data just before the window closes. Acknowledge is held back until a fixed count of timing clocks has passed, which is microsecond scale at 16 MHz. The acknowledge stays asserted until the master negates both address strobe and lower data strobe. A synchronous reset pulses the remote reset line for a fixed number of clocks. The timing clock comes from either the backplane system clock or a local oscillator, chosen by a static select.

Top module: `sio_byte_bridge`

## Requirements
- R1: A cycle is accepted only when `bus_addr[15:10]` equals `base_sel`. Address bits 9 to 7 are not decoded.
- R2: With `am_sel` = 0 only modifier code 0x29 is accepted. With `am_sel` = 1 only 0x2D is accepted. Every other code gets no strobe and no acknowledge.
- R3: A cycle with `bus_iack_n` low, or `bus_lword_n` low, or `bus_ds0_n` high (whatever `bus_ds1_n` is) causes no remote strobe and no acknowledge. `bus_ds1_n` has no effect on an accepted cycle.
- R4: `bus_dtack_n` goes low on the 43rd clock edge after `bus_as_n` and `bus_ds0_n` are presented low. That is 2 synchronizer edges, the edge that starts the count (count 0), and 40 more counted edges.
- R5: Counting from the start edge as count 0, the remote strobe is low after counts 4 through 35 and high otherwise. The strobe is `rem_wr_n` when `bus_write_n` is low and `rem_rd_n` when it is high, and the two are never low together. `rem_addr` equals `bus_addr[6:1]` throughout.
- R6: On a write, `rem_wdata` carries `bus_din` latched at the start edge, and `rem_wdata_oe` is high while the strobe window runs.
- R7: On a read, `rem_rdata` is captured on count 35, the last edge of the strobe. It is presented on `bus_dout` with `bus_doe` high while the acknowledge is asserted.
- R8: The acknowledge stays low until both `bus_as_n` and `bus_ds0_n` are seen high, and is released 3 edges after they rise. Until both are high, no new cycle starts, even if the inputs change to a matching cycle.
- R9: While `rst_n` is low, all strobes and `bus_dtack_n` are high and `rem_rst_n` is low. `rem_rst_n` stays low for exactly 16 clocks after `rst_n` rises. A reset during a cycle ends it at once.
- R10: `clk_sel` = 1 times the block from `osc_clk` and `clk_sel` = 0 from `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Backplane system clock |
| osc_clk | input | 1 | Local 16 MHz oscillator |
| clk_sel | input | 1 | Static clock select, 1 = oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | 6 | Static window select, compared with A15..A10 |
| am_sel | input | 1 | Static modifier class select |
| bus_addr | input | 15 | Bus address A15..A1 |
| bus_am | input | 6 | Address modifier code |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Lower (odd-byte) data strobe, active low |
| bus_ds1_n | input | 1 | Upper data strobe, active low |
| bus_write_n | input | 1 | Low = write, high = read |
| bus_lword_n | input | 1 | Long-word indicator, active low |
| bus_iack_n | input | 1 | Interrupt acknowledge, active low |
| bus_din | input | 8 | Bus data D07..D00 in |
| bus_dout | output | 8 | Bus data D07..D00 out |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| rem_addr | output | 6 | Remote address |
| rem_wdata | output | 8 | Remote write data |
| rem_wdata_oe | output | 1 | Remote data drive enable |
| rem_rdata | input | 8 | Remote read data |
| rem_rd_n | output | 1 | Remote read strobe, active low |
| rem_wr_n | output | 1 | Remote write strobe, active low |
| rem_rst_n | output | 1 | Remote reset, active low |

## Verification
The bench builds the bridge with its default parameters: a 40-clock acknowledge count, a strobe window from count 4 to count 36, two synchronizer stages and a 16-clock remote reset. Under these values a whole access fits in under fifty clocks, so every edge of the strobe window, the read capture edge and the acknowledge edge can be sampled one by one. At the same time the table walks every decode filter: window, modifier class, acknowledge cycle, long word and lane. The default reset length lets the bench see both the last low clock and the first high clock of the remote reset.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and sequencer state type for the short I/O bridge.
// Assumes a 16-bit bus address space and an 8-bit remote data path.
package sio_pkg;
    localparam int BUS_AW   = 16;   // short I/O address width
    localparam int WIN_LSB  = 10;   // lowest address bit of the window compare
    localparam int WIN_W    = BUS_AW - WIN_LSB;
    localparam int REM_AW   = 6;    // remote address width
    localparam int DW       = 8;    // remote and odd-lane data width
    localparam int AM_W     = 6;    // address modifier width

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a selected cycle
        ST_RUN  = 2'd1,   // counting the strobe window
        ST_HOLD = 2'd2,   // acknowledge asserted, waiting for release
        ST_SKIP = 2'd3    // cycle not for us, waiting for release
    } seq_state_t;
endpackage

// File: rtl/sio_clksel.sv
`timescale 1ns/1ps
// Module: sio_clksel
// Picks the timing clock of the bridge from the backplane clock or the
// local oscillator. Assumes the select is static, changed only while the
// block is held in reset.
module sio_clksel (
    input  logic sys_clk,
    input  logic osc_clk,
    input  logic clk_sel,
    output logic clk_o
);
    // Static two-way clock choice.
    assign clk_o = clk_sel ? osc_clk : sys_clk;
endmodule

// File: rtl/sio_sync.sv
`timescale 1ns/1ps
// Module: sio_sync
// Multi-stage synchronizer for asynchronous active-low bus strobes.
// Resets to all ones (strobes negated). Assumes STAGES >= 1.
module sio_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw strobes through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_decode.sv
`timescale 1ns/1ps
// Module: sio_decode
// Combinational slave select: window compare on the upper address bits,
// modifier class compare and cycle-type filters. Assumes the address,
// modifier and qualifiers are stable while the strobes are low.
module sio_decode
    import sio_pkg::*;
#(
    parameter logic [AM_W-1:0] AM_CODE0 = 6'h29,
    parameter logic [AM_W-1:0] AM_CODE1 = 6'h2D
) (
    input  logic [BUS_AW-1:WIN_LSB] addr_hi,
    input  logic [WIN_W-1:0]        base_sel,
    input  logic [AM_W-1:0]         am,
    input  logic                    am_sel,
    input  logic                    iack_n,
    input  logic                    lword_n,
    output logic                    hit
);
    logic [AM_W-1:0] am_want;
    logic            win_ok;
    logic            am_ok;
    logic            type_ok;

    // Modifier code selected by the static class input.
    always_comb begin
        am_want = am_sel ? AM_CODE1 : AM_CODE0;
    end

    // Window, modifier and cycle-type filters combined.
    always_comb begin
        win_ok  = (addr_hi == base_sel);
        am_ok   = (am == am_want);
        type_ok = iack_n && lword_n;
        hit     = win_ok && am_ok && type_ok;
    end
endmodule

// File: rtl/sio_rst_stretch.sv
`timescale 1ns/1ps
// Module: sio_rst_stretch
// Holds the remote reset low during reset and for RST_CLKS clocks after
// reset is released.
module sio_rst_stretch #(
    parameter int RST_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic rem_rst_n
);
    localparam int RW = $clog2(RST_CLKS + 1);
    localparam logic [RW-1:0] LOAD = RW'(RST_CLKS);

    logic [RW-1:0] left;

    // Load the count in reset, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= LOAD;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign rem_rst_n = (left == '0);

    // R9: the remote reset may only end while the block is out of reset.
    a_r9_rise_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rem_rst_n) |-> $past(rst_n));
endmodule

// File: rtl/sio_seq.sv
`timescale 1ns/1ps
// Module: sio_seq
// Cycle sequencer: starts on a synchronized select, latches address and
// write data, runs the remote strobe window, captures read data on the
// last strobe edge, asserts acknowledge after DTACK_CLKS counts and holds
// it until both strobes are negated. All outputs are registered.
// Assumes STB_ON < STB_OFF <= DTACK_CLKS.
module sio_seq
    import sio_pkg::*;
#(
    parameter int DTACK_CLKS = 40,
    parameter int STB_ON     = 4,
    parameter int STB_OFF    = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s_n,
    input  logic              ds0_s_n,
    input  logic              hit,
    input  logic              write_n,
    input  logic [REM_AW-1:0] addr_lo,
    input  logic [DW-1:0]     din,
    input  logic [DW-1:0]     rem_rdata,
    output logic              dtack_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [REM_AW-1:0] rem_addr,
    output logic [DW-1:0]     rem_wdata,
    output logic              rem_wdata_oe,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe
);
    localparam int CW = $clog2(DTACK_CLKS + 1);
    localparam logic [CW-1:0] C_ON   = CW'(STB_ON);
    localparam logic [CW-1:0] C_OFF  = CW'(STB_OFF);
    localparam logic [CW-1:0] C_LAT  = CW'(STB_OFF - 1);
    localparam logic [CW-1:0] C_DONE = CW'(DTACK_CLKS);

    seq_state_t    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          is_wr;
    logic          wr_cyc;
    logic          sel_now;
    logic          released;
    logic          stb_act;
    logic [DW-1:0] rd_lat;

    // Select and release conditions from the synchronized strobes.
    always_comb begin
        sel_now  = !as_s_n && !ds0_s_n;
        released = as_s_n && ds0_s_n;
    end

    // Direction of the cycle: raw input at the start edge, latched after.
    always_comb begin
        wr_cyc = (state == ST_IDLE) ? !write_n : is_wr;
    end

    // Next state and next count.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (sel_now) begin
                    state_n = hit ? ST_RUN : ST_SKIP;
                end
            end
            ST_RUN: begin
                cnt_n = cnt + 1'b1;
                if (cnt_n == C_DONE) begin
                    state_n = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (released) begin
                    state_n = ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (released) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Strobe window on the next count.
    always_comb begin
        stb_act = (state_n == ST_RUN) && (cnt_n >= C_ON) && (cnt_n < C_OFF);
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Latch address, direction and write data at the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr     <= 1'b0;
            rem_addr  <= '0;
            rem_wdata <= '0;
        end else if (state == ST_IDLE && state_n == ST_RUN) begin
            is_wr     <= !write_n;
            rem_addr  <= addr_lo;
            rem_wdata <= din;
        end
    end

    // Registered remote strobes and write data enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n         <= 1'b1;
            wr_n         <= 1'b1;
            rem_wdata_oe <= 1'b0;
        end else begin
            rd_n         <= !(stb_act && !wr_cyc);
            wr_n         <= !(stb_act && wr_cyc);
            rem_wdata_oe <= (state_n == ST_RUN) && wr_cyc;
        end
    end

    // Capture remote read data on the last edge of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lat <= '0;
        end else if (state_n == ST_RUN && cnt_n == C_LAT && !wr_cyc) begin
            rd_lat <= rem_rdata;
        end
    end

    // Acknowledge and bus data enable follow the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtack_n <= 1'b1;
            bus_doe <= 1'b0;
        end else begin
            dtack_n <= (state_n != ST_HOLD);
            bus_doe <= (state_n == ST_HOLD) && !wr_cyc;
        end
    end

    assign bus_dout = rd_lat;

    // R5: read and write strobes are never low together.
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5: a strobe is low only while the window is counting.
    a_r5_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (state == ST_RUN));

    // R4: acknowledge falls only when the full count has elapsed.
    a_r4_ack_at_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> (cnt == C_DONE));

    // R8: acknowledge holds while either strobe is still low.
    a_r8_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !released) |=> !dtack_n);

    // R9: reset leaves acknowledge and strobes negated.
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (dtack_n && rd_n && wr_n));
endmodule

// File: rtl/sio_byte_bridge.sv
`timescale 1ns/1ps
// Module: sio_byte_bridge (top)
// Short I/O slave that bridges odd-lane byte accesses onto a slow strobed
// remote bus. Assumes base_sel, am_sel and clk_sel are static, and that
// clk_sel changes only while rst_n is low.
module sio_byte_bridge
    import sio_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              DTACK_CLKS  = 40,
    parameter int              STB_ON      = 4,
    parameter int              STB_OFF     = 36,
    parameter int              RST_CLKS    = 16,
    parameter logic [AM_W-1:0] AM_CODE0    = 6'h29,
    parameter logic [AM_W-1:0] AM_CODE1    = 6'h2D
) (
    input  logic               sys_clk,
    input  logic               osc_clk,
    input  logic               clk_sel,
    input  logic               rst_n,
    input  logic [WIN_W-1:0]   base_sel,
    input  logic               am_sel,
    input  logic [BUS_AW-1:1]  bus_addr,
    input  logic [AM_W-1:0]    bus_am,
    input  logic               bus_as_n,
    input  logic               bus_ds0_n,
    input  logic               bus_ds1_n,
    input  logic               bus_write_n,
    input  logic               bus_lword_n,
    input  logic               bus_iack_n,
    input  logic [DW-1:0]      bus_din,
    output logic [DW-1:0]      bus_dout,
    output logic               bus_doe,
    output logic               bus_dtack_n,
    output logic [REM_AW-1:0]  rem_addr,
    output logic [DW-1:0]      rem_wdata,
    output logic               rem_wdata_oe,
    input  logic [DW-1:0]      rem_rdata,
    output logic               rem_rd_n,
    output logic               rem_wr_n,
    output logic               rem_rst_n
);
    logic       clk_i;
    logic [1:0] strb_s;
    logic       hit;
    logic       unused_ok;

    // Upper lane strobe and mid address bits take no part in the decode.
    assign unused_ok = ^{bus_ds1_n, bus_addr[WIN_LSB-1:REM_AW+1]};

    sio_clksel i_clksel (
        .sys_clk (sys_clk),
        .osc_clk (osc_clk),
        .clk_sel (clk_sel),
        .clk_o   (clk_i)
    );

    sio_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     ({bus_as_n, bus_ds0_n}),
        .q     (strb_s)
    );

    sio_decode #(.AM_CODE0(AM_CODE0), .AM_CODE1(AM_CODE1)) i_decode (
        .addr_hi  (bus_addr[BUS_AW-1:WIN_LSB]),
        .base_sel (base_sel),
        .am       (bus_am),
        .am_sel   (am_sel),
        .iack_n   (bus_iack_n),
        .lword_n  (bus_lword_n),
        .hit      (hit)
    );

    sio_seq #(
        .DTACK_CLKS (DTACK_CLKS),
        .STB_ON     (STB_ON),
        .STB_OFF    (STB_OFF)
    ) i_seq (
        .clk          (clk_i),
        .rst_n        (rst_n),
        .as_s_n       (strb_s[1]),
        .ds0_s_n      (strb_s[0]),
        .hit          (hit),
        .write_n      (bus_write_n),
        .addr_lo      (bus_addr[REM_AW:1]),
        .din          (bus_din),
        .rem_rdata    (rem_rdata),
        .dtack_n      (bus_dtack_n),
        .rd_n         (rem_rd_n),
        .wr_n         (rem_wr_n),
        .rem_addr     (rem_addr),
        .rem_wdata    (rem_wdata),
        .rem_wdata_oe (rem_wdata_oe),
        .bus_dout     (bus_dout),
        .bus_doe      (bus_doe)
    );

    sio_rst_stretch #(.RST_CLKS(RST_CLKS)) i_rst (
        .clk       (clk_i),
        .rst_n     (rst_n),
        .rem_rst_n (rem_rst_n)
    );
endmodule

// File: tb/test_sio_byte_bridge.sv
`timescale 1ns/1ps
// Bench: table of bus cycles walked by one loop, then directed reset,
// release, skip, mid-cycle reset and clock-select tests.
module test_sio_byte_bridge;
    localparam realtime CLK_PERIOD = 62.5;   // 16 MHz oscillator
    localparam realtime SYS_PERIOD = 100.0;  // backplane clock
    localparam int STB_LO_K = 7;    // first sample with strobe low
    localparam int STB_HI_K = 39;   // first sample with strobe high again
    localparam int LAT_K    = 38;   // edge that captures read data
    localparam int ACK_K    = 43;   // first sample with acknowledge low
    localparam logic [5:0] BASE = 6'h2A;  // window at 0xA800

    typedef struct packed {
        logic [15:0] addr;
        logic [5:0]  am;
        logic        ams;
        logic        wr_n;
        logic        ds0_n;
        logic        ds1_n;
        logic        lword_n;
        logic        iack_n;
        logic [7:0]  dat;
        logic        ack;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{16'hA803, 6'h29, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 4'd1},
        '{16'hA87F, 6'h29, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 4'd1},
        '{16'hA841, 6'h2D, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE7, 1'b1, 4'd2},
        '{16'hA841, 6'h29, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 4'd2},
        '{16'hAC01, 6'h29, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h22, 1'b0, 4'd1},
        '{16'hA805, 6'h29, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h33, 1'b0, 4'd3},
        '{16'hA805, 6'h29, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 1'b0, 4'd3},
        '{16'hA805, 6'h29, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 4'd3},
        '{16'hA80B, 6'h29, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 1'b1, 4'd3},
        '{16'hA805, 6'h2D, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h66, 1'b0, 4'd2}
    };

    logic osc_clk = 1'b0, sys_clk = 1'b0, osc_run = 1'b1;
    logic clk_sel = 1'b1, rst_n = 1'b0, am_sel = 1'b0;
    logic [15:0] addr = '0;
    logic [5:0] am = '0;
    logic as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, write_n = 1'b1;
    logic lword_n = 1'b1, iack_n = 1'b1;
    logic [7:0] din = '0, rem_rdata = '0;
    logic [7:0] bus_dout, rem_wdata;
    logic [5:0] rem_addr;
    logic bus_doe, dtack_n, rem_wdata_oe, rem_rd_n, rem_wr_n, rem_rst_n;
    int n_chk = 0, n_fail = 0;
    logic tclk;

    always #(CLK_PERIOD/2) if (osc_run) osc_clk = ~osc_clk;
    always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
    assign tclk = clk_sel ? osc_clk : sys_clk;

    sio_byte_bridge i_sio_byte_bridge (
        .sys_clk(sys_clk), .osc_clk(osc_clk), .clk_sel(clk_sel), .rst_n(rst_n),
        .base_sel(BASE), .am_sel(am_sel), .bus_addr(addr[15:1]), .bus_am(am),
        .bus_as_n(as_n), .bus_ds0_n(ds0_n), .bus_ds1_n(ds1_n),
        .bus_write_n(write_n), .bus_lword_n(lword_n), .bus_iack_n(iack_n),
        .bus_din(din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_dtack_n(dtack_n), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
        .rem_wdata_oe(rem_wdata_oe), .rem_rdata(rem_rdata),
        .rem_rd_n(rem_rd_n), .rem_wr_n(rem_wr_n), .rem_rst_n(rem_rst_n)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge, then park at the following falling edge.
    task automatic step();
        @(posedge tclk);
        @(negedge tclk);
    endtask

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic release_bus(input bit acked);
        as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1;
        step(); step();
        if (acked) chk(!dtack_n, "R8 ack held through sync", 16'(dtack_n), 16'h0);
        step();
        chk(dtack_n && !bus_doe, "R8 ack released", {14'h0, dtack_n, bus_doe}, 16'h2);
        step();
    endtask

    task automatic run_vec(input vec_t v);
        bit any_stb = 1'b0, any_ack = 1'b0;
        addr = v.addr; am = v.am; am_sel = v.ams; write_n = v.wr_n;
        lword_n = v.lword_n; iack_n = v.iack_n; din = v.dat;
        rem_rdata = ~v.dat;
        as_n = 1'b0; ds0_n = v.ds0_n; ds1_n = v.ds1_n;
        for (int k = 1; k <= 46; k++) begin
            step();
            if (!v.ack) begin
                any_stb |= !(rem_rd_n && rem_wr_n);
                any_ack |= !dtack_n;
            end else begin
                if (k == STB_LO_K - 1)
                    chk(rem_rd_n && rem_wr_n, "R5 strobe before window",
                        {14'h0, rem_rd_n, rem_wr_n}, 16'h3);
                if (k == STB_LO_K) begin
                    chk(rem_rd_n == !v.wr_n && rem_wr_n == v.wr_n, "R5 strobe opens",
                        {14'h0, rem_rd_n, rem_wr_n}, {14'h0, !v.wr_n, v.wr_n});
                    chk(rem_addr == v.addr[6:1], "R5 remote address",
                        16'(rem_addr), 16'(v.addr[6:1]));
                    if (!v.wr_n)
                        chk(rem_wdata == v.dat && rem_wdata_oe, "R6 write data",
                            {7'h0, rem_wdata_oe, rem_wdata}, {8'h1, v.dat});
                end
                if (k == LAT_K - 1 && v.wr_n) rem_rdata = v.dat;
                if (k == LAT_K) begin
                    chk(!(rem_rd_n && rem_wr_n), "R5 strobe still low at count 35",
                        {14'h0, rem_rd_n, rem_wr_n}, {14'h0, !v.wr_n, v.wr_n});
                    rem_rdata = ~v.dat;
                end
                if (k == STB_HI_K)
                    chk(rem_rd_n && rem_wr_n, "R5 strobe closed",
                        {14'h0, rem_rd_n, rem_wr_n}, 16'h3);
                if (k == ACK_K - 1)
                    chk(dtack_n, "R4 no early ack", 16'(dtack_n), 16'h1);
                if (k == ACK_K) begin
                    chk(!dtack_n, "R4 ack on edge 43", 16'(dtack_n), 16'h0);
                    if (v.wr_n)
                        chk(bus_doe && bus_dout == v.dat, "R7 read data on bus",
                            {7'h0, bus_doe, bus_dout}, {8'h1, v.dat});
                end
            end
        end
        if (!v.ack)
            chk(!any_stb && !any_ack, tag(v.req),
                {14'h0, any_stb, any_ack}, 16'h0);
        release_bus(v.ack);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit stb_seen, ack_seen;
        @(negedge tclk);
        step(); step(); step();
        // R9: reset state
        chk(dtack_n && rem_rd_n && rem_wr_n && !rem_rst_n, "R9 reset state",
            {12'h0, dtack_n, rem_rd_n, rem_wr_n, rem_rst_n}, 16'hE);
        rst_n = 1'b1;
        for (int i = 0; i < 15; i++) step();
        chk(!rem_rst_n, "R9 remote reset held 15", 16'(rem_rst_n), 16'h0);
        step();
        chk(rem_rst_n, "R9 remote reset ends at 16", 16'(rem_rst_n), 16'h1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: acknowledge held while lower data strobe stays low
        addr = 16'hA803; am = 6'h29; am_sel = 1'b0; write_n = 1'b1;
        lword_n = 1'b1; iack_n = 1'b1;
        as_n = 1'b0; ds0_n = 1'b0;
        for (int k = 1; k <= ACK_K; k++) step();
        as_n = 1'b1;
        stb_seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step();
            stb_seen |= !(rem_rd_n && rem_wr_n);
        end
        chk(!dtack_n && !stb_seen, "R8 held with only AS negated",
            {14'h0, dtack_n, stb_seen}, 16'h0);
        release_bus(1'b1);

        // R8: a skipped cycle turning into a match is not started
        addr = 16'hAC01; as_n = 1'b0; ds0_n = 1'b0;
        for (int k = 0; k < 6; k++) step();
        addr = 16'hA803;
        stb_seen = 1'b0; ack_seen = 1'b0;
        for (int k = 0; k < 50; k++) begin
            step();
            stb_seen |= !(rem_rd_n && rem_wr_n);
            ack_seen |= !dtack_n;
        end
        chk(!stb_seen && !ack_seen, "R8 no restart before release",
            {14'h0, stb_seen, ack_seen}, 16'h0);
        release_bus(1'b0);

        // R9: reset in the middle of a strobe window
        write_n = 1'b0; din = 8'h9D; as_n = 1'b0; ds0_n = 1'b0;
        for (int k = 0; k < 20; k++) step();
        rst_n = 1'b0;
        step();
        chk(rem_rd_n && rem_wr_n && dtack_n && !rem_rst_n, "R9 mid-cycle reset",
            {13'h0, rem_rd_n, rem_wr_n, dtack_n}, 16'h7);
        as_n = 1'b1; ds0_n = 1'b1;
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 17; k++) step();

        // R10: run from the backplane clock with the oscillator stopped
        rst_n = 1'b0;
        step();
        osc_run = 1'b0; clk_sel = 1'b0;
        @(negedge tclk);
        step(); step();
        rst_n = 1'b1;
        for (int k = 0; k < 17; k++) step();
        write_n = 1'b1; as_n = 1'b0; ds0_n = 1'b0;
        for (int k = 1; k < ACK_K; k++) step();
        chk(dtack_n, "R10 no early ack on system clock", 16'(dtack_n), 16'h1);
        step();
        chk(!dtack_n, "R10 ack on system clock", 16'(dtack_n), 16'h0);
        release_bus(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule